// File: doc/BRIEF.md
# Word-Wide One-Time-Programmable ROM Pin Model

This block is a clocked, synthesizable model of a 16-bit-wide one-time-programmable read-only memory as a board sees it from its pins. A small decoder looks at active-low chip select, active-low output gate, a programming-supply flag and an identification flag. The identification flag stands for the raised voltage on the address line that selects the identification codes. The decoder then picks one of six modes: read, output-off, standby, program, program-inhibit or identification read.

The array lives in an internal register file. Its depth is set by `ADDR_W`. The full part has 21 address bits, and a smaller value keeps simulation cheap. Every location starts erased at 0xFFFF. A program pulse can only pull bits from 1 to 0. The pin-level tristate bus appears as a drive-enable flag (`dout_en`) plus a data word (`dout`), and a separate `din` port carries write data. Access time is a fixed count of clock edges, `LAT`. An access state machine has the states IDLE, WAIT and VALID:
- IDLE moves to WAIT when the mode becomes read or identification.
- WAIT moves back to WAIT, with the counter restarted, when the address or the mode changes.
- WAIT moves to VALID when the count reaches `LAT`.
- VALID moves to WAIT when the address or the mode changes.
- Any state moves to IDLE when the mode is none of the two reading modes.

Top module: `wordrom_emu`

## Requirements
- R1: After reset every location reads 0xFFFF and `prog_err` is 0. A one-cycle `erase_all` pulse sets every location back to 0xFFFF and clears `prog_err`.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hi`=0 (read mode), `dout` shows the word stored at `addr` once `dout_valid` is 1.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 (output-off mode), `dout_en` is 0 one edge later.
- R4: With `ce_n`=1 (standby or program-inhibit), `dout_en`, `dout_valid` and `dout` are all 0 one edge later, whatever `oe_n` is. Whenever `dout_valid` is 0, `dout` is 0.
- R5: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hi`=1 (identification mode), `dout` is 0x0020 when `addr[0]`=0 and 0x0034 when `addr[0]`=1. Bits 15 to 8 are always 0 in this mode.
- R6: `dout_valid` rises exactly `LAT` clock edges after the edge that first samples a new reading mode or a new address. The edge that samples the change clears it, and `dout_valid` only ever rises while `dout_en` is 1.
- R7: With `vpp_hi`=1, each falling step of `ce_n` (sampled low after being sampled high) writes once. The location becomes its old value ANDed with `din`, so bits can only go from 1 to 0. `dout_en` stays 0 in program mode.
- R8: With `vpp_hi`=1 and `ce_n`=1 (program-inhibit), nothing is written, whatever `din` and `addr` are.
- R9: A program pulse with `id_hi`=1 writes nothing and sets `prog_err` to 1.
- R10: `prog_err` stays 1 until reset or `erase_all`, including across later successful program pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming supply at programming level |
| id_hi | input | 1 | Identification level on the address line |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Program data |
| erase_all | input | 1 | Sets the whole array back to 0xFFFF and clears `prog_err` |
| dout | output | 16 | Read data; 0 whenever not valid |
| dout_en | output | 1 | Bus drive enable (high means the bus is driven, low means high impedance) |
| dout_valid | output | 1 | Access time has elapsed; `dout` holds the word |
| prog_err | output | 1 | Sticky flag: a program pulse arrived together with the identification flag |

## Verification
The bench builds the block with `ADDR_W`=6 and `LAT`=3. With 64 words, one erase visibly restores a location that was programmed. A latency of three leaves two edges of WAIT between the restart and VALID, so an off-by-one in the counter shows up as a wrong edge count. The same latency also lets the bench see the restart when the address changes while VALID is held.

// File: rtl/wre_pkg.sv
package wre_pkg;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] MFR_CODE = 16'h0020;
    localparam logic [WORD_W-1:0] DEV_CODE = 16'h0034;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_OFF,
        MD_READ,
        MD_SIG,
        MD_PROG
    } wre_mode_e;

    typedef enum logic [1:0] {
        AS_IDLE,
        AS_WAIT,
        AS_VALID
    } wre_acc_e;
endpackage

// File: rtl/wre_mode_dec.sv
module wre_mode_dec
    import wre_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_hi,
    input  logic      id_hi,
    output wre_mode_e mode
);
    always_comb begin
        if (ce_n)
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (vpp_hi)
            mode = MD_PROG;
        else if (oe_n)
            mode = MD_OFF;
        else if (id_hi)
            mode = MD_SIG;
        else
            mode = MD_READ;
    end
endmodule

// File: rtl/wre_array.sv
module wre_array
    import wre_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= cells[waddr] & wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '1;
        else        rdata <= cells[raddr];
    end
endmodule

// File: rtl/wre_access.sv
module wre_access
    import wre_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wre_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              drive,
    output logic              valid
);
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    wre_acc_e          state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    wre_mode_e         mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic              reading, restart;

    assign reading = (mode == MD_READ) || (mode == MD_SIG);
    assign restart = (mode != mode_q) || (addr != addr_q);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            AS_IDLE: begin
                if (reading) begin
                    state_nx = AS_WAIT;
                    cnt_nx   = CNT_W'(1);
                end
            end
            AS_WAIT: begin
                if (!reading) begin
                    state_nx = AS_IDLE;
                end else if (restart) begin
                    cnt_nx = CNT_W'(1);
                end else if (cnt >= CNT_W'(LAT)) begin
                    state_nx = AS_VALID;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            AS_VALID: begin
                if (!reading) begin
                    state_nx = AS_IDLE;
                end else if (restart) begin
                    state_nx = AS_WAIT;
                    cnt_nx   = CNT_W'(1);
                end
            end
            default: state_nx = AS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= AS_IDLE;
            cnt    <= '0;
            mode_q <= MD_STANDBY;
            addr_q <= '0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            mode_q <= mode;
            addr_q <= addr;
        end
    end

    always_comb begin
        drive = (state != AS_IDLE);
        valid = (state == AS_VALID);
    end
endmodule

// File: rtl/wordrom_emu.sv
module wordrom_emu
    import wre_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    input  logic              erase_all,
    output logic [15:0]       dout,
    output logic              dout_en,
    output logic              dout_valid,
    output logic              prog_err
);
    wre_mode_e   mode;
    logic        ce_q, id_q, a0_q;
    logic        pulse, we;
    logic [15:0] rdata;

    wre_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hi  (id_hi),
        .mode   (mode)
    );

    assign pulse = (mode == MD_PROG) && ce_q;
    assign we    = pulse && !id_hi && !erase_all;

    wre_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase_all),
        .we    (we),
        .waddr (addr),
        .wdata (din),
        .raddr (addr),
        .rdata (rdata)
    );

    wre_access #(.ADDR_W(ADDR_W), .LAT(LAT)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .addr  (addr),
        .drive (dout_en),
        .valid (dout_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q     <= 1'b1;
            id_q     <= 1'b0;
            a0_q     <= 1'b0;
            prog_err <= 1'b0;
        end else begin
            ce_q <= ce_n;
            id_q <= id_hi;
            a0_q <= addr[0];
            if (erase_all)
                prog_err <= 1'b0;
            else if (pulse && id_hi)
                prog_err <= 1'b1;
        end
    end

    always_comb begin
        if (!dout_valid)
            dout = '0;
        else if (id_q)
            dout = a0_q ? DEV_CODE : MFR_CODE;
        else
            dout = rdata;
    end
endmodule

// File: rtl/wre_checker.sv
module wre_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              id_hi,
    input logic [ADDR_W-1:0] addr,
    input logic              erase_all,
    input logic [15:0]       dout,
    input logic              dout_en,
    input logic              dout_valid,
    input logic              prog_err
);
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dout_en && !dout_valid)); // R4

    AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hi) |=> !dout_en); // R3

    AST_PROG_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hi) |=> !dout_en); // R7

    AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> dout_en); // R6

    AST_ADDR_MOVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !$stable(addr)) |=> !dout_valid); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> (dout == 16'h0000)); // R4

    AST_SIG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && $past(id_hi)) |-> (dout[15:8] == 8'h00)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !erase_all) |=> prog_err); // R10

    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> !prog_err); // R1
endmodule

bind wordrom_emu wre_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .vpp_hi     (vpp_hi),
    .id_hi      (id_hi),
    .addr       (addr),
    .erase_all  (erase_all),
    .dout       (dout),
    .dout_en    (dout_en),
    .dout_valid (dout_valid),
    .prog_err   (prog_err)
);

// File: tb/wordrom_emu_tb.sv
`timescale 1ns/1ps
module wordrom_emu_tb;
    localparam int AW  = 6;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic          erase_all = 1'b0;
    logic [15:0]   dout;
    logic          dout_en, dout_valid, prog_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wordrom_emu #(.ADDR_W(AW), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .id_hi(id_hi), .addr(addr), .din(din), .erase_all(erase_all),
        .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid), .prog_err(prog_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic go_standby();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hi = 1'b0;
        edge_sample();
    endtask

    // read (or identification) from standby; checks latency and value
    task automatic t_read(input logic [AW-1:0] a, input logic id, input logic [15:0] exp,
                          input string tag);
        int n = 0;
        go_standby();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; id_hi = id; addr = a;
        edge_sample();
        n = 1;
        chk({tag, " R6 drive after first edge"}, {31'b0, dout_en}, 32'd1);
        while (!dout_valid && n < 20) begin
            edge_sample();
            n++;
        end
        chk({tag, " R6 edges to valid"}, n, LAT + 1);
        chk(tag, {16'b0, dout}, {16'b0, exp});
    endtask

    task automatic t_prog(input logic [AW-1:0] a, input logic [15:0] d, input logic id);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b1; id_hi = id; addr = a; din = d;
        edge_sample();
        @(negedge clk);
        ce_n = 1'b0;
        edge_sample();
        chk("R7 no drive while programming", {31'b0, dout_en}, 32'd0);
        @(negedge clk);
        ce_n = 1'b1;
        edge_sample();
        @(negedge clk);
        vpp_hi = 1'b0; id_hi = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 prog_err after reset", {31'b0, prog_err}, 32'd0);
        chk("R4 no drive after reset", {31'b0, dout_en}, 32'd0);
        t_read(6'd0, 1'b0, 16'hFFFF, "R1 erased word 0");
        t_read(6'd63, 1'b0, 16'hFFFF, "R1 erased word 63");
    endtask

    task automatic t_program_and();
        t_prog(6'd5, 16'h1234, 1'b0);
        t_read(6'd5, 1'b0, 16'h1234, "R2/R7 read after first program");
        t_prog(6'd5, 16'hFF0F, 1'b0);
        t_read(6'd5, 1'b0, 16'h1204, "R7 second program ANDs");
        t_prog(6'd6, 16'hFFFF, 1'b0);
        t_read(6'd6, 1'b0, 16'hFFFF, "R7 all-ones keeps erased");
    endtask

    task automatic t_addr_move();
        int n = 0;
        t_prog(6'd9, 16'hA5A5, 1'b0);
        t_read(6'd5, 1'b0, 16'h1204, "R2 read word 5");
        @(negedge clk);
        addr = 6'd9;
        edge_sample();
        n = 1;
        chk("R6 valid drops on address move", {31'b0, dout_valid}, 32'd0);
        while (!dout_valid && n < 20) begin
            edge_sample();
            n++;
        end
        chk("R6 edges to valid after move", n, LAT + 1);
        chk("R2 read word 9 after move", {16'b0, dout}, 32'h0000A5A5);
    endtask

    task automatic t_signature();
        t_read(6'd0, 1'b1, 16'h0020, "R5 maker code");
        t_read(6'd1, 1'b1, 16'h0034, "R5 device code");
        t_read(6'd5, 1'b1, 16'h0034, "R5 odd address ignores array");
    endtask

    task automatic t_output_off();
        t_read(6'd5, 1'b0, 16'h1204, "R2 read before gate off");
        @(negedge clk);
        oe_n = 1'b1;
        edge_sample();
        chk("R3 drive off with gate high", {31'b0, dout_en}, 32'd0);
        chk("R4 dout zero when off", {16'b0, dout}, 32'd0);
    endtask

    task automatic t_standby();
        t_read(6'd5, 1'b0, 16'h1204, "R2 read before standby");
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        edge_sample();
        chk("R4 standby drive off", {31'b0, dout_en}, 32'd0);
        chk("R4 standby valid off", {31'b0, dout_valid}, 32'd0);
        chk("R4 standby dout zero", {16'b0, dout}, 32'd0);
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        ce_n = 1'b1; vpp_hi = 1'b1; addr = 6'd7; din = 16'h0000;
        repeat (4) edge_sample();
        chk("R8 inhibit no drive", {31'b0, dout_en}, 32'd0);
        @(negedge clk);
        vpp_hi = 1'b0;
        t_read(6'd7, 1'b0, 16'hFFFF, "R8 inhibit writes nothing");
    endtask

    task automatic t_prog_err();
        t_prog(6'd8, 16'h0000, 1'b1);
        chk("R9 error flag set", {31'b0, prog_err}, 32'd1);
        t_read(6'd8, 1'b0, 16'hFFFF, "R9 flagged pulse writes nothing");
        t_prog(6'd10, 16'h00FF, 1'b0);
        chk("R10 flag held after good pulse", {31'b0, prog_err}, 32'd1);
        t_read(6'd10, 1'b0, 16'h00FF, "R7 good pulse still writes");
    endtask

    task automatic t_erase();
        @(negedge clk);
        erase_all = 1'b1;
        edge_sample();
        @(negedge clk);
        erase_all = 1'b0;
        chk("R1 erase clears flag", {31'b0, prog_err}, 32'd0);
        t_read(6'd5, 1'b0, 16'hFFFF, "R1 erase restores word 5");
        t_read(6'd10, 1'b0, 16'hFFFF, "R1 erase restores word 10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_program_and();
        t_addr_move();
        t_signature();
        t_output_off();
        t_standby();
        t_inhibit();
        t_prog_err();
        t_erase();
        go_standby();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule